// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit-Manipulation Execution Unit

This unit executes the prefixed group of an 8-bit accumulator CPU, covering rotates and shifts, single-bit tests, bit clears and bit sets, on one byte operand. The opcode is split into three fields: a two-bit class, a three-bit sub-operation or bit index, and a three-bit operand selector. The selector names one of seven working registers or the memory byte that the surrounding core has already fetched from the HL address. From these fields the unit forms the result byte, the write-back target, the new flag byte and the instruction's cycle count.

The datapath is purely combinational. An output stage loads all of it when `in_valid` is high and presents it one clock later, with the write strobes lasting a single cycle. The surrounding core supplies the register values, the memory read data, the current flags and its internal 16-bit address latch. Only the high byte of that latch is used, and only by a memory-operand bit test, where it provides the two undocumented flag bits.

Top module: `cbx_unit`

## Requirements
- R1: Opcode bits 7..6 give the class (00 shift/rotate, 01 bit test, 10 bit clear, 11 bit set). Bits 5..3 give the sub-operation or bit index. Bits 2..0 select the operand in the order B=0, C=1, D=2, E=3, H=4, L=5, memory=6, A=7, and `reg_sel` echoes that selector.
- R2: Sub-operations 0..3 of the shift class are, in order: rotate left circular, rotate right circular, rotate left through the old carry (flag bit 0), and rotate right through the old carry. In each case the new carry is the bit that leaves the byte.
- R3: Sub-operation 4 shifts left and inserts a 0. Sub-operation 5 shifts right and keeps bit 7. Sub-operation 7 shifts right and inserts a 0. The new carry is the bit that leaves the byte.
- R4: Sub-operation 6 shifts left and forces result bit 0 to 1, and the new carry is the old bit 7.
- R5: The flag byte layout is S=7, Z=6, Y=5, H=4, X=3, P/V=2, N=1, C=0. For shift-class operations, S, Y and X copy result bits 7, 5 and 3. Z is set when the result is zero, P/V is set when the result has an even number of ones, and H and N are cleared.
- R6: A bit test sets both Z and P/V to the inverse of the tested bit, sets H, clears N and keeps C. S is set only when the index is 7 and the tested bit is 1.
- R7: For a register-operand bit test, Y and X copy bits 5 and 3 of the operand. For the memory-operand bit test, they copy bits 5 and 3 of the address latch's high byte.
- R8: Bit clear and bit set force the indexed bit to 0 or 1, keep every other bit, and pass the incoming flags out unchanged.
- R9: A bit test never asserts either write strobe, and its `result` carries the operand unchanged.
- R10: A memory-operand instruction that writes asserts `mem_we` and not `reg_we`. A register-operand instruction that writes does the reverse. The two strobes are never high together.
- R11: `cycles` is 8 for every register form, 12 for the memory bit test, and 15 for every other memory form.
- R12: Outputs load on the clock edge where `in_valid` is high and appear one cycle later with `out_valid` high. The strobes and `out_valid` last one cycle, and `result`, `flags_out` and `cycles` hold while no instruction arrives. After reset `out_valid`, `reg_we` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Prefixed opcode byte |
| rf_b | input | 8 | Register B |
| rf_c | input | 8 | Register C |
| rf_d | input | 8 | Register D |
| rf_e | input | 8 | Register E |
| rf_h | input | 8 | Register H |
| rf_l | input | 8 | Register L |
| rf_a | input | 8 | Accumulator A |
| mem_rdata | input | 8 | Byte read from the HL address |
| flags_in | input | 8 | Current flag byte |
| addr_latch | input | 16 | Internal address latch of the core |
| out_valid | output | 1 | Registered outputs belong to a new instruction |
| result | output | 8 | Result byte |
| reg_sel | output | 3 | Write-back register selector |
| reg_we | output | 1 | Register write strobe |
| mem_we | output | 1 | Memory write strobe |
| flags_out | output | 8 | New flag byte |
| cycles | output | 4 | Cycle count of the instruction |

## Verification
In a memory-operand bit test, two operations fall in the same cycle: the bit test on the fetched byte and the capture of the undocumented X and Y flags from the address latch. The bench provokes this by giving the memory byte and the latch's high byte opposite values in bits 5 and 3. It then checks that Z and P/V follow the memory byte while Y and X follow the latch, and that the register form of the same test with the same operand copies the operand's bits instead. The rotate-through-carry forms likewise read the old carry and produce the new one in a single evaluation, so they are driven with the carry set and with it clear.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 3;
  localparam int NSRC    = 1 << SEL_W;
  localparam int MEM_SEL = 6;
  localparam int ADDR_W  = 16;

  // flag byte positions
  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_Y = 5;
  localparam int FL_H = 4;
  localparam int FL_X = 3;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_TEST  = 2'b01,
    CLS_CLR   = 2'b10,
    CLS_SET   = 2'b11
  } cls_e;

  typedef struct packed {
    cls_e             cls;
    logic [2:0]       sub;
    logic [SEL_W-1:0] sel;
    logic             on_mem;
  } dec_t;
endpackage

// File: rtl/cbx_decode.sv
module cbx_decode
  import cbx_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output dec_t              dec
);
  always_comb begin
    dec.cls    = cls_e'(opcode[7:6]);
    dec.sub    = opcode[5:3];
    dec.sel    = opcode[SEL_W-1:0];
    dec.on_mem = (opcode[SEL_W-1:0] == SEL_W'(MEM_SEL));
  end
endmodule

// File: rtl/cbx_shift.sv
module cbx_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd,
  input  logic         cin,
  input  logic [2:0]   sub,
  output logic [W-1:0] res,
  output logic         cout
);
  logic out_left;
  always_comb begin
    out_left = ~sub[0];
    unique case (sub)
      3'd0: res = {opnd[W-2:0], opnd[W-1]};
      3'd1: res = {opnd[0], opnd[W-1:1]};
      3'd2: res = {opnd[W-2:0], cin};
      3'd3: res = {cin, opnd[W-1:1]};
      3'd4: res = {opnd[W-2:0], 1'b0};
      3'd5: res = {opnd[W-1], opnd[W-1:1]};
      3'd6: res = {opnd[W-2:0], 1'b1};
      default: res = {1'b0, opnd[W-1:1]};
    endcase
    cout = out_left ? opnd[W-1] : opnd[0];
  end
endmodule

// File: rtl/cbx_bitop.sv
module cbx_bitop #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  opnd,
  input  logic [IW-1:0] idx,
  input  logic          do_set,
  output logic [W-1:0]  res,
  output logic          tested
);
  logic [W-1:0] mask;
  always_comb begin
    mask   = '0;
    mask[idx] = 1'b1;
    res    = do_set ? (opnd | mask) : (opnd & ~mask);
    tested = |(opnd & mask);
  end
endmodule

// File: rtl/cbx_unit.sv
module cbx_unit
  import cbx_pkg::*;
#(
  parameter int CYC_REG      = 8,
  parameter int CYC_TEST_MEM = 12,
  parameter int CYC_RMW_MEM  = 15,
  localparam int CYC_W = $clog2(CYC_RMW_MEM + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [BYTE_W-1:0]    opcode,
  input  logic [BYTE_W-1:0]    rf_b,
  input  logic [BYTE_W-1:0]    rf_c,
  input  logic [BYTE_W-1:0]    rf_d,
  input  logic [BYTE_W-1:0]    rf_e,
  input  logic [BYTE_W-1:0]    rf_h,
  input  logic [BYTE_W-1:0]    rf_l,
  input  logic [BYTE_W-1:0]    rf_a,
  input  logic [BYTE_W-1:0]    mem_rdata,
  input  logic [BYTE_W-1:0]    flags_in,
  input  logic [ADDR_W-1:0]    addr_latch,
  output logic                 out_valid,
  output logic [BYTE_W-1:0]    result,
  output logic [SEL_W-1:0]     reg_sel,
  output logic                 reg_we,
  output logic                 mem_we,
  output logic [BYTE_W-1:0]    flags_out,
  output logic [CYC_W-1:0]     cycles
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  dec_t dec;
  cbx_decode u_dec (.opcode(opcode), .dec(dec));

  // operand selection
  logic [BYTE_W-1:0] src [NSRC];
  logic [BYTE_W-1:0] opnd;
  assign src[0] = rf_b;
  assign src[1] = rf_c;
  assign src[2] = rf_d;
  assign src[3] = rf_e;
  assign src[4] = rf_h;
  assign src[5] = rf_l;
  assign src[6] = mem_rdata;
  assign src[7] = rf_a;
  assign opnd   = src[dec.sel];

  logic [BYTE_W-1:0] sh_res, bo_res;
  logic              sh_c, bo_tested;

  cbx_shift #(.W(BYTE_W)) u_sh (
    .opnd(opnd), .cin(flags_in[FL_C]), .sub(dec.sub),
    .res(sh_res), .cout(sh_c)
  );

  cbx_bitop #(.W(BYTE_W)) u_bo (
    .opnd(opnd), .idx(dec.sub), .do_set(dec.cls == CLS_SET),
    .res(bo_res), .tested(bo_tested)
  );

  // next-state logic
  logic [BYTE_W-1:0] res_n, fl_n, xy_src;
  logic [CYC_W-1:0]  cyc_n;
  logic              writes, rwe_n, mwe_n;

  always_comb begin
    xy_src = dec.on_mem ? addr_latch[ADDR_W-1 -: BYTE_W] : opnd;
    res_n  = opnd;
    fl_n   = flags_in;
    unique case (dec.cls)
      CLS_SHIFT: begin
        res_n       = sh_res;
        fl_n        = '0;
        fl_n[FL_S]  = sh_res[7];
        fl_n[FL_Z]  = (sh_res == '0);
        fl_n[FL_Y]  = sh_res[5];
        fl_n[FL_X]  = sh_res[3];
        fl_n[FL_P]  = ~^sh_res;
        fl_n[FL_C]  = sh_c;
      end
      CLS_TEST: begin
        res_n       = opnd;
        fl_n[FL_S]  = bo_tested & (dec.sub == 3'd7);
        fl_n[FL_Z]  = ~bo_tested;
        fl_n[FL_Y]  = xy_src[5];
        fl_n[FL_H]  = 1'b1;
        fl_n[FL_X]  = xy_src[3];
        fl_n[FL_P]  = ~bo_tested;
        fl_n[FL_N]  = 1'b0;
      end
      default: res_n = bo_res;
    endcase
    writes = (dec.cls != CLS_TEST);
    rwe_n  = in_valid & writes & ~dec.on_mem;
    mwe_n  = in_valid & writes &  dec.on_mem;
    if (!dec.on_mem)      cyc_n = CYC_W'(CYC_REG);
    else if (!writes)     cyc_n = CYC_W'(CYC_TEST_MEM);
    else                  cyc_n = CYC_W'(CYC_RMW_MEM);
  end

  // registered output stage
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      reg_we    <= 1'b0;
      mem_we    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      reg_we    <= rwe_n;
      mem_we    <= mwe_n;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      result    <= '0;
      reg_sel   <= '0;
      flags_out <= '0;
      cycles    <= '0;
    end else if (in_valid) begin
      result    <= res_n;
      reg_sel   <= dec.sel;
      flags_out <= fl_n;
      cycles    <= cyc_n;
    end
  end
endmodule

// File: rtl/cbx_unit_chk.sv
module cbx_unit_chk #(
  parameter int CYC_W = 4
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             in_valid,
  input logic [7:0]       opcode,
  input logic [7:0]       flags_in,
  input logic             out_valid,
  input logic [7:0]       result,
  input logic             reg_we,
  input logic             mem_we,
  input logic [7:0]       flags_out,
  input logic [CYC_W-1:0] cycles
);
  // R9
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(in_valid) && $past(opcode[7:6]) == 2'b01 |-> !reg_we && !mem_we);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({reg_we, mem_we}));

  // R11
  cycle_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> (cycles == 8 || cycles == 12 || cycles == 15));

  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(in_valid) && $past(opcode[7]) |-> flags_out == $past(flags_in));

  // R6
  test_h_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(in_valid) && $past(opcode[7:6]) == 2'b01 |-> flags_out[4] && !flags_out[1]);

  // R12
  load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid && !reg_we && !mem_we && $stable(result) && $stable(flags_out));
endmodule

bind cbx_unit cbx_unit_chk #(.CYC_W(CYC_W)) u_chk (.*);

// File: tb/sim_cbx_unit.sv
module sim_cbx_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  opcode;
  logic [7:0]  rf [8];
  logic [7:0]  flags_in;
  logic [15:0] addr_latch;
  logic        out_valid, reg_we, mem_we;
  logic [7:0]  result, flags_out;
  logic [2:0]  reg_sel;
  logic [3:0]  cycles;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cbx_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .rf_b(rf[0]), .rf_c(rf[1]), .rf_d(rf[2]), .rf_e(rf[3]),
    .rf_h(rf[4]), .rf_l(rf[5]), .rf_a(rf[7]), .mem_rdata(rf[6]),
    .flags_in(flags_in), .addr_latch(addr_latch),
    .out_valid(out_valid), .result(result), .reg_sel(reg_sel),
    .reg_we(reg_we), .mem_we(mem_we), .flags_out(flags_out), .cycles(cycles)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference built from the requirements
  task automatic model(input logic [7:0] op, output logic [7:0] r, output logic [7:0] f,
                       output logic rw, output logic mw, output int cyc);
    logic [7:0] v, x;
    logic c;
    int ones, k;
    v = rf[op[2:0]];
    k = op[5:3];
    f = flags_in;
    r = v;
    if (op[7:6] == 2'b00) begin
      case (k)
        0: begin r = (v << 1) | (v >> 7); c = v[7]; end
        1: begin r = (v >> 1) | (v << 7); c = v[0]; end
        2: begin r = (v << 1) | {7'd0, flags_in[0]}; c = v[7]; end
        3: begin r = (v >> 1) | {flags_in[0], 7'd0}; c = v[0]; end
        4: begin r = v << 1; c = v[7]; end
        5: begin r = (v >> 1) | (v & 8'h80); c = v[0]; end
        6: begin r = (v << 1) | 8'h01; c = v[7]; end
        default: begin r = v >> 1; c = v[0]; end
      endcase
      ones = 0;
      for (int i = 0; i < 8; i++) ones += r[i];
      f = {r[7], r == 0, r[5], 1'b0, r[3], ones % 2 == 0, 1'b0, c};
    end else if (op[7:6] == 2'b01) begin
      x = (op[2:0] == 6) ? addr_latch[15:8] : v;
      f = {(k == 7) && v[7], !v[k], x[5], 1'b1, x[3], !v[k], 1'b0, flags_in[0]};
    end else if (op[7:6] == 2'b10) r = v & ~(8'd1 << k);
    else r = v | (8'd1 << k);
    rw = (op[7:6] != 2'b01) && (op[2:0] != 6);
    mw = (op[7:6] != 2'b01) && (op[2:0] == 6);
    cyc = (op[2:0] != 6) ? 8 : (op[7:6] == 2'b01 ? 12 : 15);
  endtask

  task automatic issue(input logic [7:0] op);
    @(negedge clk);
    opcode   = op;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 out_valid after reset", out_valid, 0);
    chk("R12 reg_we after reset", reg_we, 0);
    chk("R12 mem_we after reset", mem_we, 0);
  endtask

  task automatic t_rotates;
    rf[0] = 8'h81; flags_in = 8'h00; issue(8'h00);
    chk("R2 RLC result", result, 8'h03); chk("R5 RLC flags", flags_out, 8'h05);
    rf[1] = 8'h01; issue(8'h09);
    chk("R2 RRC result", result, 8'h80); chk("R5 RRC flags", flags_out, 8'h81);
    rf[2] = 8'h80; flags_in = 8'h01; issue(8'h12);
    chk("R2 RL carry in result", result, 8'h01); chk("R2 RL flags", flags_out, 8'h01);
    rf[3] = 8'h01; flags_in = 8'h00; issue(8'h1B);
    chk("R2 RR result", result, 8'h00); chk("R5 RR zero flags", flags_out, 8'h45);
    chk("R1 RR reg_sel", reg_sel, 3); chk("R10 RR reg_we", reg_we, 1);
  endtask

  task automatic t_shifts;
    rf[7] = 8'hFF; issue(8'h27);
    chk("R3 SLA result", result, 8'hFE); chk("R5 SLA flags", flags_out, 8'hA9);
    rf[0] = 8'h81; issue(8'h28);
    chk("R3 SRA result", result, 8'hC0); chk("R5 SRA flags", flags_out, 8'h85);
    rf[5] = 8'h01; issue(8'h3D);
    chk("R3 SRL result", result, 8'h00); chk("R5 SRL flags", flags_out, 8'h45);
    rf[7] = 8'h80; issue(8'h37);
    chk("R4 SLL result", result, 8'h01); chk("R4 SLL flags", flags_out, 8'h01);
  endtask

  task automatic t_bit_tests;
    rf[7] = 8'h80; flags_in = 8'h01; issue(8'h7F);
    chk("R6 bit7 flags", flags_out, 8'h91); chk("R9 bit7 result", result, 8'h80);
    chk("R9 bit7 reg_we", reg_we, 0); chk("R11 bit reg cycles", cycles, 8);
    // memory byte and latch high byte disagree in bits 5 and 3
    rf[6] = 8'h28; addr_latch = 16'h0000; flags_in = 8'h00; issue(8'h46);
    chk("R7 mem bit flags", flags_out, 8'h54); chk("R9 mem bit mem_we", mem_we, 0);
    chk("R11 mem bit cycles", cycles, 12);
    rf[6] = 8'h00; addr_latch = 16'h28FF; issue(8'h46);
    chk("R7 latch bits flags", flags_out, 8'h7C);
    rf[0] = 8'h28; addr_latch = 16'h0000; issue(8'h40);
    chk("R7 reg bit flags", flags_out, 8'h7C);
  endtask

  task automatic t_res_set;
    rf[6] = 8'hFF; flags_in = 8'hA5; issue(8'h9E);
    chk("R8 RES mem result", result, 8'hF7); chk("R8 RES flags", flags_out, 8'hA5);
    chk("R10 RES mem_we", mem_we, 1); chk("R10 RES reg_we", reg_we, 0);
    chk("R11 RES mem cycles", cycles, 15);
    rf[4] = 8'h00; issue(8'hFC);
    chk("R8 SET result", result, 8'h80); chk("R1 SET reg_sel", reg_sel, 4);
    chk("R10 SET reg_we", reg_we, 1); chk("R11 SET cycles", cycles, 8);
  endtask

  task automatic t_hold;
    logic [7:0] r0, f0;
    rf[2] = 8'h5A; issue(8'hD2);
    r0 = result; f0 = flags_out;
    chk("R12 out_valid pulse", out_valid, 1);
    @(negedge clk);
    chk("R12 out_valid drops", out_valid, 0);
    chk("R12 reg_we drops", reg_we, 0);
    rf[2] = 8'h00; flags_in = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R12 result held", result, r0);
    chk("R12 flags held", flags_out, f0);
  endtask

  task automatic t_sweep;
    logic [7:0] er, ef;
    logic erw, emw;
    int ecyc;
    string tag;
    for (int op = 0; op < 256; op++) begin
      for (int i = 0; i < 8; i++) rf[i] = 8'((op * 29 + i * 71) ^ (op >> 2));
      flags_in   = 8'(op * 37 + 11);
      addr_latch = 16'((op * 151) << 4);
      issue(8'(op));
      model(8'(op), er, ef, erw, emw, ecyc);
      case (op[7:6])
        2'b00:   tag = "R5 sweep shift";
        2'b01:   tag = "R6 sweep test";
        default: tag = "R8 sweep clear/set";
      endcase
      chk({tag, " result"}, result, er);
      chk({tag, " flags"}, flags_out, ef);
      chk("R1 sweep reg_sel", reg_sel, op[2:0]);
      chk("R10 sweep reg_we", reg_we, erw);
      chk("R10 sweep mem_we", mem_we, emw);
      chk("R11 sweep cycles", cycles, ecyc);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12 actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; opcode = 8'h00;
    flags_in = 8'h00; addr_latch = 16'h0000;
    for (int i = 0; i < 8; i++) rf[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rotates();
    t_shifts();
    t_bit_tests();
    t_res_set();
    t_hold();
    t_sweep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule